// File: doc/BRIEF.md
# Oversampled NRZI Line Decoder with Sync-Gap Lock

This block receives an NRZI-coded serial audio line that is not related to the local clock and recovers its data bits using a system clock several times faster than the bit rate. It has no prior knowledge of the exact line rate. Instead, it waits for the long idle run that marks the frame boundary: ten zero bits framed by two one bits. It measures that run in system-clock cycles and derives the bit period from it. It then samples each bit in the middle of its period and emits it with a single-cycle strobe.

A two-state controller supervises the decoder. In the hunting state it looks for an edge-to-edge interval of plausible sync length. In the decoding state it keeps emitting bits and re-aligns its bit phase on every line transition. It drops back to hunting in two cases: when the line stops toggling for longer than any legal frame allows, or when a frame parser further downstream pulses the invalid input. Frame parsing itself is done downstream.

Top module: `nrzi_lock_decoder`

## Requirements
- R1: From reset the block is hunting, with `bit_o` and `bit_en_o` at 0. While hunting, `bit_en_o` never rises.
- R2: Lock happens only on a line edge whose distance from the previous edge lies within GAP_MIN..GAP_MAX system cycles (defaults 64..120), and only if an earlier edge has been seen since reset. Shorter intervals, longer intervals and the first edge after a long idle are ignored.
- R3: The bit period is the locked interval divided by SYNC_ZEROS+1 (eleven), rounded to nearest. Each bit is sampled half a period after the last edge or period boundary.
- R4: The first bit emitted after lock is the 1 carried by the edge that closed the sync gap. The zeros of the gap that caused the lock are never emitted.
- R5: While decoding, a bit period that contains a line transition yields 1 and a period without one yields 0. `bit_o` holds that value while `bit_en_o` is high.
- R6: `bit_en_o` is high for exactly one system cycle per recovered bit and is never high in two consecutive cycles.
- R7: When the line stops toggling, the block keeps emitting 0 bits until ZERO_LIMIT zeros (default 11) have been emitted in a row. It then returns to hunting and emits nothing further.
- R8: A one-cycle pulse on `invalid_i` puts the block in the hunting state on the next cycle and suppresses any further strobe. The block then relocks on the next qualifying sync gap.
- R9: A legal in-stream run of ten zeros followed by a one does not disturb decoding; the stream continues bit for bit across frame boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times the line bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Asynchronous NRZI serial line |
| invalid_i | input | 1 | One-cycle request to drop lock and hunt for the next sync gap |
| bit_o | output | 1 | Recovered data bit, valid while `bit_en_o` is high |
| bit_en_o | output | 1 | One-cycle strobe per recovered bit |

## Verification
The bench instantiates the block with its default parameters: an 8-bit interval counter, a lock window of 64 to 120 cycles, and a zero limit of eleven. It drives the line at 7, 8 and 9 system cycles per bit. These rates place the sync gap at 77, 88 and 99 cycles, all inside the window, while the longest in-frame run of 5 bits (35 to 45 cycles) stays below it. Rounding of the period measurement is therefore exercised at three rates. A deliberate 16-bit silence (128 cycles) and a 7-bit silence (56 cycles) probe the window from above and below. The loss threshold of eleven sits one bit beyond the legal ten-zero gap, so the bench can show that the legal gap passes and the interruption trips.

// File: rtl/nrzi_pkg.sv
package nrzi_pkg;

  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_DECODE = 1'b1
  } lock_state_t;

endpackage

// File: rtl/nrzi_line_sync.sv
module nrzi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic edge_o
);

  // shr[STAGES-1] is the last synchroniser flop, shr[STAGES] its delayed copy
  logic [STAGES:0] shr_q;
  logic [STAGES:0] shr_d;

  always_comb begin
    shr_d = {shr_q[STAGES-1:0], line_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shr_q <= '0;
    end else begin
      shr_q <= shr_d;
    end
  end

  assign edge_o = shr_q[STAGES] ^ shr_q[STAGES-1];

endmodule

// File: rtl/nrzi_gap_meter.sv
module nrzi_gap_meter #(
  parameter int CNT_W    = 8,
  parameter int GAP_MIN  = 64,
  parameter int GAP_MAX  = 120,
  parameter int GAP_SPAN = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  input  logic             hunt_i,
  output logic             gap_hit_o,
  output logic [CNT_W-1:0] period_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] GAP_LO  = CNT_W'(GAP_MIN);
  localparam logic [CNT_W-1:0] GAP_HI  = CNT_W'(GAP_MAX);
  localparam logic [CNT_W:0]   RND     = (CNT_W+1)'(GAP_SPAN / 2);
  localparam logic [CNT_W:0]   DIV     = (CNT_W+1)'(GAP_SPAN);
  localparam logic [CNT_W-1:0] PER_LO  = CNT_W'(GAP_MIN / GAP_SPAN);
  localparam logic [CNT_W-1:0] PER_HI  = CNT_W'((GAP_MAX + GAP_SPAN) / GAP_SPAN);

  logic [CNT_W-1:0] run_q, run_d;
  logic             armed_q, armed_d;
  logic [CNT_W:0]   sum;
  logic [CNT_W:0]   quo;

  // cycles since the last edge, saturating; value 1 in the cycle after an edge
  always_comb begin
    run_d   = run_q;
    armed_d = armed_q;
    if (edge_i) begin
      run_d   = CNT_W'(1);
      armed_d = 1'b1;
    end else if (run_q != CNT_TOP) begin
      run_d = run_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      armed_q <= armed_d;
    end
  end

  assign gap_hit_o = hunt_i && edge_i && armed_q &&
                     (run_q >= GAP_LO) && (run_q <= GAP_HI);

  assign sum      = {1'b0, run_q} + RND;
  assign quo      = sum / DIV;
  assign period_o = quo[CNT_W-1:0];

  // R3
  period_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_hit_o |-> ((period_o >= PER_LO) && (period_o <= PER_HI)));

endmodule

// File: rtl/nrzi_bit_slicer.sv
module nrzi_bit_slicer #(
  parameter int CNT_W      = 8,
  parameter int ZERO_LIMIT = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             edge_i,
  input  logic             block_i,
  output logic             smp_en_o,
  output logic             smp_bit_o,
  output logic             starve_o
);

  localparam int            ZW    = $clog2(ZERO_LIMIT + 1);
  localparam logic [ZW-1:0] ZTOP  = ZW'(ZERO_LIMIT);
  localparam logic [ZW-1:0] ZLAST = ZW'(ZERO_LIMIT - 1);

  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] ph_q, ph_d;
  logic             flag_q, flag_d;
  logic [ZW-1:0]    zrun_q, zrun_d;
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] last;
  logic             smp;

  assign half = {1'b0, per_q[CNT_W-1:1]};
  assign last = per_q - CNT_W'(1);
  assign smp  = active_i && !block_i && !edge_i && (ph_q == half);

  always_comb begin
    per_d  = per_q;
    ph_d   = ph_q;
    flag_d = flag_q;
    zrun_d = zrun_q;
    if (load_i) begin
      per_d  = period_i;
      ph_d   = '0;
      flag_d = 1'b1;
      zrun_d = '0;
    end else if (active_i) begin
      if (edge_i) begin
        ph_d   = '0;
        flag_d = 1'b1;
      end else begin
        ph_d = (ph_q == last) ? '0 : ph_q + CNT_W'(1);
        if (smp) begin
          flag_d = 1'b0;
          if (flag_q) begin
            zrun_d = '0;
          end else if (zrun_q != ZTOP) begin
            zrun_d = zrun_q + ZW'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      ph_q   <= '0;
      flag_q <= 1'b0;
      zrun_q <= '0;
    end else begin
      per_q  <= per_d;
      ph_q   <= ph_d;
      flag_q <= flag_d;
      zrun_q <= zrun_d;
    end
  end

  assign smp_en_o  = smp;
  assign smp_bit_o = flag_q;
  assign starve_o  = smp && !flag_q && (zrun_q == ZLAST);

  // R3
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (ph_q < per_q));

  // R6
  sample_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en_o |=> !smp_en_o);

endmodule

// File: rtl/nrzi_lock_decoder.sv
module nrzi_lock_decoder
  import nrzi_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SYNC_ZEROS  = 10,
  parameter int GAP_MIN     = 64,
  parameter int GAP_MAX     = 120,
  parameter int ZERO_LIMIT  = SYNC_ZEROS + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic invalid_i,
  output logic bit_o,
  output logic bit_en_o
);

  localparam int GAP_SPAN = SYNC_ZEROS + 1;

  lock_state_t      state_q, state_d;
  logic             edge_w;
  logic             hunt_w;
  logic             gap_hit_w;
  logic [CNT_W-1:0] period_w;
  logic             smp_en_w;
  logic             smp_bit_w;
  logic             starve_w;
  logic             bit_q, bit_d;
  logic             en_q;

  nrzi_line_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (line_i),
    .edge_o (edge_w)
  );

  assign hunt_w = (state_q == ST_HUNT) && !invalid_i;

  nrzi_gap_meter #(
    .CNT_W    (CNT_W),
    .GAP_MIN  (GAP_MIN),
    .GAP_MAX  (GAP_MAX),
    .GAP_SPAN (GAP_SPAN)
  ) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_i    (edge_w),
    .hunt_i    (hunt_w),
    .gap_hit_o (gap_hit_w),
    .period_o  (period_w)
  );

  nrzi_bit_slicer #(
    .CNT_W      (CNT_W),
    .ZERO_LIMIT (ZERO_LIMIT)
  ) u_slicer (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_i  (state_q == ST_DECODE),
    .load_i    (gap_hit_w),
    .period_i  (period_w),
    .edge_i    (edge_w),
    .block_i   (invalid_i),
    .smp_en_o  (smp_en_w),
    .smp_bit_o (smp_bit_w),
    .starve_o  (starve_w)
  );

  always_comb begin
    state_d = state_q;
    if (invalid_i) begin
      state_d = ST_HUNT;
    end else begin
      case (state_q)
        ST_HUNT:   if (gap_hit_w) state_d = ST_DECODE;
        ST_DECODE: if (starve_w)  state_d = ST_HUNT;
        default:   state_d = ST_HUNT;
      endcase
    end
  end

  always_comb begin
    bit_d = bit_q;
    if (smp_en_w) begin
      bit_d = smp_bit_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      bit_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      en_q    <= smp_en_w;
    end
  end

  assign bit_o    = bit_q;
  assign bit_en_o = en_q;

  // R1
  strobe_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en_o |-> ($past(state_q) == ST_DECODE));

  // R2
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DECODE) && ($past(state_q) == ST_HUNT)) |-> $past(gap_hit_w));

  // R6
  en_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en_o |=> !bit_en_o);

  // R8
  invalid_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_i |=> ((state_q == ST_HUNT) && !bit_en_o));

endmodule

// File: tb/sim_nrzi_lock_decoder.sv
`timescale 1ns/1ps
module sim_nrzi_lock_decoder;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_r = 1'b0;
  logic inv_r = 1'b0;
  logic bit_o;
  logic bit_en_o;

  int n_chk = 0;
  int n_err = 0;
  int b2b = 0;
  int split = 0;
  bit prev_en = 1'b0;
  bit q[$];
  logic sbit [0:1023];

  always #10 clk = ~clk;

  nrzi_lock_decoder u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_i    (line_r),
    .invalid_i (inv_r),
    .bit_o     (bit_o),
    .bit_en_o  (bit_en_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_en_o) begin
        q.push_back(bit_o);
        if (prev_en) b2b++;
      end
      prev_en = bit_en_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Four frames: separator 1, 4 user bits, 48 x (1 + nibble), separator 1, ten zeros
  task automatic build(input logic [15:0] seed);
    logic [15:0] lf = seed;
    int p = 0;
    for (int f = 0; f < 4; f++) begin
      sbit[p] = 1'b1; p++;
      for (int u = 0; u < 4; u++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        sbit[p] = lf[0]; p++;
      end
      for (int g = 0; g < 48; g++) begin
        sbit[p] = 1'b1; p++;
        for (int n = 0; n < 4; n++) begin
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          sbit[p] = lf[0]; p++;
        end
      end
      sbit[p] = 1'b1; p++;
      for (int z = 0; z < 10; z++) begin
        sbit[p] = 1'b0; p++;
      end
    end
  endtask

  task automatic drive(input int first, input int count, input int cpb, input int pulse_idx);
    for (int i = first; i < first + count; i++) begin
      if (sbit[i]) line_r = ~line_r;
      if (i == pulse_idx) inv_r = 1'b1;
      for (int k = 0; k < cpb; k++) begin
        @(posedge clk); #1;
        if (k == 0 && i == pulse_idx) begin
          inv_r = 1'b0;
          split = q.size();
        end
      end
    end
  endtask

  task automatic idle(input int cycles);
    repeat (cycles) @(posedge clk);
    #1;
  endtask

  task automatic cmp(input int qofs, input int sofs, input int n, input string req);
    int mm = 0;
    int first_bad = -1;
    for (int i = 0; i < n; i++) begin
      if ((qofs + i) >= q.size() || q[qofs + i] != sbit[sofs + i]) begin
        mm++;
        if (first_bad < 0) first_bad = i;
      end
    end
    chk(mm == 0, req, mm, 0);
    if (mm != 0) $display("  first mismatch at bit %0d", first_bad);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle(5);
    @(negedge clk);
    chk(bit_en_o == 1'b0, "R1 strobe in reset", bit_en_o, 0);
    chk(bit_o == 1'b0, "R1 data in reset", bit_o, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(300);
    chk(q.size() == 0, "R1 no strobe on idle line", q.size(), 0);
  endtask

  task automatic t_no_false_lock();
    q.delete();
    for (int i = 0; i < 20; i++) begin
      line_r = ~line_r;
      idle(8);
    end
    line_r = ~line_r; idle(128);
    line_r = ~line_r; idle(56);
    line_r = ~line_r; idle(8);
    line_r = ~line_r; idle(300);
    chk(q.size() == 0, "R2 no lock on short or long intervals", q.size(), 0);
  endtask

  task automatic t_frames(input logic [15:0] seed, input int cpb, input string tag);
    int sz;
    q.delete();
    b2b = 0;
    build(seed);
    drive(0, 768, cpb, -1);
    idle(40 * cpb);
    chk(q.size() == 513, {"R7 R9 bit count ", tag}, q.size(), 513);
    chk(q.size() > 0 && q[0] == 1'b1, {"R4 first bit is separator ", tag},
        (q.size() > 0) ? int'(q[0]) : -1, 1);
    cmp(0, 256, 512, {"R3 R5 decoded stream ", tag});
    chk(q.size() > 512 && q[512] == 1'b0, {"R7 trailing zero ", tag},
        (q.size() > 512) ? int'(q[512]) : -1, 0);
    sz = q.size();
    idle(300);
    chk(q.size() == sz, {"R7 silent after loss ", tag}, q.size(), sz);
    chk(b2b == 0, {"R6 single-cycle strobes ", tag}, b2b, 0);
  endtask

  task automatic t_invalid();
    q.delete();
    b2b = 0;
    split = 0;
    build(16'h5a3c);
    drive(0, 1024, 8, 356);
    idle(320);
    chk(split > 80 && split <= 100, "R8 bits before pulse", split, 99);
    cmp(0, 256, split, "R8 prefix before pulse");
    chk(q.size() == split + 513, "R8 count after relock", q.size(), split + 513);
    chk(q.size() > split && q[split] == 1'b1, "R8 R4 relock first bit",
        (q.size() > split) ? int'(q[split]) : -1, 1);
    cmp(split, 512, 512, "R8 stream after relock");
    chk(b2b == 0, "R6 single-cycle strobes invalid", b2b, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_no_false_lock();
    t_frames(16'hace1, 8, "8cpb");
    t_frames(16'h1234, 7, "7cpb");
    t_frames(16'hbeef, 9, "9cpb");
    t_invalid();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule